// File: doc/BRIEF.md
# Five-Port X-First Mesh Router

This block is the switching element at one node of a two-dimensional mesh. It has four neighbour channels (east, west, north, south) and one channel to the local processor. Every channel is split into an inbound and an outbound half. Each half has a data word and a request/acknowledge pair that follows a four-phase handshake.

Each message is a single word. The top bits of the word are a header holding the destination column and row. The middle bits carry control and payload, and the low bits carry a trailer check code that the router passes through without reading it. Each inbound channel holds one latched message. The router compares the destination with its own coordinates, which are parameters, and resolves the column first and the row second. This ordering keeps the mesh free of deadlock. When several inputs want the same output, a rotating-priority arbiter picks one. An input that loses keeps its word until it is served.

Top module: `mesh_xy_router`

## Requirements
- R1: After reset, every `in_ack` and every `out_req` bit is low.
- R2: A word whose destination column (bits [15:14]) is greater than `MY_X` leaves on output port 1 (east).
- R3: A word whose destination column is less than `MY_X` leaves on output port 2 (west).
- R4: A word whose destination column equals `MY_X` and whose destination row (bits [13:12]) is greater than `MY_Y` leaves on port 3 (north).
- R5: A word whose destination column equals `MY_X` and whose row is less than `MY_Y` leaves on port 4 (south).
- R6: A word whose column and row both match the node leaves on port 0 (local processor).
- R7: The delivered word equals the accepted word in every bit, including the control, payload and trailer fields.
- R8: An input raises `in_ack` after it latches a request and holds it until `in_req` falls, then drops it. While that input still holds an unserved word, it does not acknowledge a new request.
- R9: An output holds `out_req` and a stable `out_data` until `out_ack` rises. After `out_req` falls, the output does not raise it again while `out_ack` is still high.
- R10: When several latched inputs compete for one output, they are served in rotating order of port index. The order starts after the last input granted on that output; after reset, port 0 has top priority. Inputs that lose keep their words.
- R11: An output that is stalled does not delay words bound for other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 5 | Inbound request, one bit per port (0 local, 1 east, 2 west, 3 north, 4 south) |
| in_ack | output | 5 | Inbound acknowledge, one bit per port |
| in_data | input | 5x16 | Inbound word for each port |
| out_req | output | 5 | Outbound request, one bit per port |
| out_ack | input | 5 | Outbound acknowledge, one bit per port |
| out_data | output | 5x16 | Outbound word for each port |

## Verification
A corrupted routing decision shows up as a word on the wrong output within a few cycles of acceptance, so every destination in the 4x4 mesh is swept from every input. A wrong arbiter pointer changes the order in which a stalled output drains its contenders, and that order is checked against an arithmetic rotation. A lost or mishandled buffer flag shows either as an acknowledge given to a blocked input or as a word that never arrives. Both are observed directly on the channel wires.

// File: rtl/mesh_rt_pkg.sv
package mesh_rt_pkg;
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_EAST  = 3'd1,
    P_WEST  = 3'd2,
    P_NORTH = 3'd3,
    P_SOUTH = 3'd4
  } port_e;

  // Column is resolved completely before the row is looked at.
  function automatic port_e xy_route(input int dst_x, input int dst_y,
                                     input int own_x, input int own_y);
    if (dst_x > own_x)      return P_EAST;
    else if (dst_x < own_x) return P_WEST;
    else if (dst_y > own_y) return P_NORTH;
    else if (dst_y < own_y) return P_SOUTH;
    else                    return P_LOCAL;
  endfunction
endpackage

// File: rtl/mr_in_latch.sv
module mr_in_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  output logic         ack,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         full,
  output logic [W-1:0] dout
);
  logic take;
  assign take = req && !ack && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack  <= 1'b0;
      full <= 1'b0;
      dout <= '0;
    end else begin
      if (ack && !req) ack <= 1'b0;
      else if (take)   ack <= 1'b1;
      if (take) begin
        full <= 1'b1;
        dout <= din;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end

  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack && req |=> ack);
  p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !req |=> !ack);
endmodule

// File: rtl/mr_rr_arb.sv
module mr_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          any;

  always_comb begin
    gnt = '0;
    win = ptr;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + 1 + k) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        win      = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ptr <= PW'(N - 1);
    else if (adv && any) ptr <= win;
  end

  p_gnt_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
endmodule

// File: rtl/mr_out_chan.sv
module mr_out_chan #(
  parameter int N = 5,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        cand,
  input  logic [N-1:0][W-1:0] cand_data,
  output logic [N-1:0]        gnt,
  output logic                out_req,
  input  logic                out_ack,
  output logic [W-1:0]        out_data
);
  typedef enum logic [1:0] {O_IDLE, O_BUSY, O_DRAIN} ostate_e;
  ostate_e st;

  logic         idle;
  logic [N-1:0] arb_gnt;
  logic [W-1:0] sel;

  assign idle = (st == O_IDLE);

  mr_rr_arb #(.N(N)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(cand), .adv(idle), .gnt(arb_gnt)
  );

  assign gnt = idle ? arb_gnt : '0;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) sel = cand_data[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= O_IDLE;
      out_req  <= 1'b0;
      out_data <= '0;
    end else begin
      unique case (st)
        O_IDLE: if (|gnt) begin
          out_data <= sel;
          out_req  <= 1'b1;
          st       <= O_BUSY;
        end
        O_BUSY: if (out_ack) begin
          out_req <= 1'b0;
          st      <= O_DRAIN;
        end
        O_DRAIN: if (!out_ack) st <= O_IDLE;
        default: st <= O_IDLE;
      endcase
    end
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_req && !out_ack |=> out_req && $stable(out_data));
  p_no_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req && out_ack |=> !out_req);
endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router
  import mesh_rt_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COORD_W = 2,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_req,
  output logic [NPORT-1:0]              in_ack,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
  output logic [NPORT-1:0]              out_req,
  input  logic [NPORT-1:0]              out_ack,
  output logic [NPORT-1:0][DATA_W-1:0]  out_data
);
  localparam int XHI = DATA_W - 1;
  localparam int YHI = DATA_W - COORD_W - 1;

  logic [NPORT-1:0]             full_v;
  logic [NPORT-1:0]             pop_v;
  logic [NPORT-1:0][DATA_W-1:0] lat_data;
  port_e                        rsel [NPORT];
  logic [NPORT-1:0][NPORT-1:0]  want;     // [output][input]
  logic [NPORT-1:0][NPORT-1:0]  gnt;      // [output][input]
  logic [NPORT-1:0][NPORT-1:0]  gnt_col;  // [input][output]

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    mr_in_latch #(.W(DATA_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .req(in_req[i]), .ack(in_ack[i]),
      .din(in_data[i]), .pop(pop_v[i]), .full(full_v[i]), .dout(lat_data[i])
    );

    always_comb
      rsel[i] = xy_route(int'(lat_data[i][XHI -: COORD_W]),
                         int'(lat_data[i][YHI -: COORD_W]), MY_X, MY_Y);

    p_loser_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      full_v[i] && !pop_v[i] |=> full_v[i] && $stable(lat_data[i]));
    p_single_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_col[i]));
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++) begin
        want[o][i]    = full_v[i] && (int'(rsel[i]) == o);
        gnt_col[i][o] = gnt[o][i];
      end
    for (int i = 0; i < NPORT; i++)
      pop_v[i] = |gnt_col[i];
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    mr_out_chan #(.N(NPORT), .W(DATA_W)) u_out (
      .clk(clk), .rst_n(rst_n), .cand(want[o]), .cand_data(lat_data),
      .gnt(gnt[o]), .out_req(out_req[o]), .out_ack(out_ack[o]),
      .out_data(out_data[o])
    );
  end
endmodule

// File: tb/mesh_xy_router_test.sv
`timescale 1ns/1ps
module mesh_xy_router_test;
  localparam int MX = 1;
  localparam int MY = 2;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] in_req = '0;
  logic [NP-1:0] in_ack;
  logic [NP-1:0][15:0] in_data = '0;
  logic [NP-1:0] out_req;
  logic [NP-1:0] out_ack = '0;
  logic [NP-1:0][15:0] out_data;

  int n_tests = 0;
  int n_fail = 0;
  int viol_r9 = 0;
  logic [NP-1:0] sink_en = '1;
  logic [NP-1:0] prev_req = '0;
  logic [15:0] rxq [NP][$];
  int last_src [NP];

  always #2 clk = ~clk;

  mesh_xy_router #(.DATA_W(16), .COORD_W(2), .MY_X(MX), .MY_Y(MY)) uut (
    .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_ack(in_ack),
    .in_data(in_data), .out_req(out_req), .out_ack(out_ack),
    .out_data(out_data)
  );

  // Outbound sinks: four-phase responders acting on the falling edge.
  always @(negedge clk) begin
    for (int o = 0; o < NP; o++) begin
      if (out_req[o] && !prev_req[o] && out_ack[o]) viol_r9++;
      prev_req[o] = out_req[o];
      if (rst_n && sink_en[o] && out_req[o] && !out_ack[o]) begin
        rxq[o].push_back(out_data[o]);
        last_src[o] = int'(out_data[o][11:8]);
        out_ack[o] = 1'b1;
      end else if (!out_req[o] && out_ack[o]) begin
        out_ack[o] = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic logic [15:0] mk(input int dx, input int dy, input int src, input int pay);
    logic [3:0] p;
    p = 4'(pay);
    return {2'(dx), 2'(dy), 4'(src), p, p ^ {2'(dx), 2'(dy)}};
  endfunction

  function automatic int expect_port(input int dx, input int dy);
    int ddx = dx - MX;
    int ddy = dy - MY;
    if (ddx != 0) return (ddx > 0) ? 1 : 2;
    if (ddy != 0) return (ddy > 0) ? 3 : 4;
    return 0;
  endfunction

  task automatic send(input int s, input logic [15:0] w);
    @(negedge clk);
    in_data[s] = w;
    in_req[s] = 1'b1;
    while (!in_ack[s]) @(negedge clk);
    in_req[s] = 1'b0;
    while (in_ack[s]) @(negedge clk);
  endtask

  task automatic clear_q();
    for (int o = 0; o < NP; o++) rxq[o].delete();
  endtask

  task automatic rr_case(input logic [NP-1:0] mask, input int pay);
    int order[$];
    int l;
    l = last_src[1];
    for (int k = 1; k <= NP; k++)
      if (mask[(l + k) % NP]) order.push_back((l + k) % NP);
    clear_q();
    sink_en[1] = 1'b0;
    fork
      if (mask[0]) send(0, mk(3, 0, 0, pay));
      if (mask[1]) send(1, mk(3, 1, 1, pay));
      if (mask[2]) send(2, mk(3, 2, 2, pay));
      if (mask[3]) send(3, mk(3, 3, 3, pay));
      if (mask[4]) send(4, mk(2, 0, 4, pay));
    join
    repeat (5) @(negedge clk);
    sink_en[1] = 1'b1;
    repeat (40) @(negedge clk);
    check(rxq[1].size() == order.size(), "R10",
          $sformatf("east count %0d expected %0d", rxq[1].size(), order.size()));
    for (int k = 0; k < order.size() && k < rxq[1].size(); k++)
      check(int'(rxq[1][k][11:8]) == order[k], "R10",
            $sformatf("slot %0d source %0d expected %0d", k, rxq[1][k][11:8], order[k]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int o = 0; o < NP; o++) last_src[o] = NP - 1;
    repeat (4) @(negedge clk);
    check(in_ack == '0 && out_req == '0, "R1",
          $sformatf("in_ack=%b out_req=%b expected 0", in_ack, out_req));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Full sweep: every input, every destination of the 4x4 mesh.
    for (int s = 0; s < NP; s++)
      for (int dx = 0; dx < 4; dx++)
        for (int dy = 0; dy < 4; dy++) begin
          logic [15:0] w;
          int e;
          int others;
          string tag;
          w = mk(dx, dy, s, dx * 4 + dy);
          e = expect_port(dx, dy);
          tag = (e == 1) ? "R2" : (e == 2) ? "R3" : (e == 3) ? "R4" : (e == 4) ? "R5" : "R6";
          clear_q();
          send(s, w);
          check(in_ack[s] == 1'b0, "R8", "ack still high after request fell");
          repeat (8) @(negedge clk);
          others = 0;
          for (int o = 0; o < NP; o++) if (o != e) others += rxq[o].size();
          check(rxq[e].size() == 1 && others == 0, tag,
                $sformatf("src %0d dst (%0d,%0d): port %0d got %0d, others %0d, expected 1/0",
                          s, dx, dy, e, rxq[e].size(), others));
          if (rxq[e].size() == 1)
            check(rxq[e][0] == w, "R7",
                  $sformatf("word %h expected %h", rxq[e][0], w));
        end

    // Blocked output, single-word buffer, independence of other outputs.
    begin
      logic [15:0] wa, wb, wc, wd;
      wa = mk(3, 2, 0, 1);
      wb = mk(2, 1, 0, 2);
      wc = mk(3, 3, 0, 3);
      wd = mk(0, 0, 2, 4);
      clear_q();
      sink_en[1] = 1'b0;
      send(0, wa);
      repeat (4) @(negedge clk);
      check(out_req[1] && out_data[1] == wa, "R9",
            $sformatf("stalled req=%b data=%h expected 1/%h", out_req[1], out_data[1], wa));
      send(0, wb);
      in_data[0] = wc;
      in_req[0] = 1'b1;
      repeat (10) @(negedge clk);
      check(in_ack[0] == 1'b0, "R8", "full input acknowledged a new word, expected no ack");
      send(2, wd);
      repeat (8) @(negedge clk);
      check(rxq[2].size() == 1 && rxq[2][0] == wd, "R11",
            $sformatf("west got %0d words while east stalled, expected 1", rxq[2].size()));
      check(out_req[1] && out_data[1] == wa, "R9",
            $sformatf("held data %h expected %h", out_data[1], wa));
      sink_en[1] = 1'b1;
      while (!in_ack[0]) @(negedge clk);
      in_req[0] = 1'b0;
      while (in_ack[0]) @(negedge clk);
      repeat (20) @(negedge clk);
      check(rxq[1].size() == 3, "R8",
            $sformatf("east delivered %0d words, expected 3", rxq[1].size()));
      if (rxq[1].size() == 3)
        check(rxq[1][0] == wa && rxq[1][1] == wb && rxq[1][2] == wc, "R7",
              $sformatf("order %h %h %h expected %h %h %h",
                        rxq[1][0], rxq[1][1], rxq[1][2], wa, wb, wc));
    end

    // Contention on one output with rotating priority.
    rr_case(5'b11111, 5);
    rr_case(5'b10101, 6);
    rr_case(5'b01010, 7);
    rr_case(5'b11001, 8);

    check(viol_r9 == 0, "R9",
          $sformatf("request re-raised under high ack %0d times, expected 0", viol_r9));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule